// File: doc/BRIEF.md
# Flash Command Register State Machine

This block is the command interpreter on the device side of a word-wide, bulk-erase flash memory of 65536 words of 16 bits. The chip-enable, write-enable and output-enable strobes, a 16-bit address and a 16-bit data word are brought into the clock domain through synchronisers. A write cycle is recognised on a rising edge of the synchronised write enable while chip enable is low and output enable is high. On each recognised write, the low byte of the data word is decoded as a command. The only exception is the reset word, which is compared in full.

Each operation is a two-write sequence: a set-up write followed by a confirming write. Once started, an erase or a program runs until a verify command stops it. The block has no internal completion timer. Verify modes redirect array reads to a latched address and raise a margin-read flag. An identifier mode returns fixed manufacturer and device codes. The memory array is outside the block. It is reached through a read-address output and a read-data input.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in read mode, with erase busy, program busy and margin read all low.
- R2: A write is accepted only on a write-enable rising edge while chip enable is low and output enable is high. A strobe pattern that does not meet this leaves the mode unchanged.
- R3: Writing low byte 20h enters erase set-up. Erase busy rises only after a second 20h write. Any other second word returns the block to read mode without erasing.
- R4: Writing low byte A0h stops a running erase and enters erase verify. The write's address is latched. Later reads return the array word at that latched address, with margin read high.
- R5: Writing low byte 40h enters program set-up. The next write of any value latches its address and data onto the program outputs and raises program busy.
- R6: Writing low byte C0h stops programming and enters program verify. Reads then return the array word at the latched program address, with margin read high.
- R7: Two consecutive writes of FFFFh return the block to read mode from any mode other than program set-up and clear both busy flags. A single FFFFh followed by a different word cancels the pending reset, and that word is then decoded as usual.
- R8: Writing low byte 90h enters identifier mode. A read with address bit 0 low returns 0020h, and with address bit 0 high returns 0050h.
- R9: The upper data byte is ignored for commands. An unrecognised low byte leaves the mode unchanged.
- R10: Erase verify persists until another valid command arrives. A further A0h write re-latches the verify address.
- R11: The mode output encodes the modes as follows: 0 read, 1 identifier, 2 erase set-up, 3 erasing, 4 erase verify, 5 program set-up, 6 programming, 7 program verify. Writing low byte 00h selects read mode, in which reads return the array word at the bus address with margin read low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 16 | Bus address |
| din | input | 16 | Bus write data |
| arr_rdata | input | 16 | Word returned by the array for rd_addr |
| mode | output | 3 | Current mode (encoding in R11) |
| erase_busy | output | 1 | Erase in progress |
| prog_busy | output | 1 | Programming in progress |
| margin_rd | output | 1 | Reads are margin reads |
| prog_addr | output | 16 | Latched program address |
| prog_data | output | 16 | Latched program data |
| rd_addr | output | 16 | Address presented to the array |
| rd_data | output | 16 | Word returned on a bus read |

## Verification
Assertions check the mode transitions on every cycle. They confirm that the mode never moves without an accepted write, that a confirming erase write starts an erase, and that a verify write stops the running operation and latches the right address. They also confirm that a program data write latches the address and data, and that a reset pair lands in read mode. Only the bench scenarios can show the behaviour at the bus. That covers rejected strobe patterns, the identifier codes, the address redirection on margin reads, cancellation of a single reset word, and the ignored upper command byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    MD_READ        = 3'd0,
    MD_IDENT       = 3'd1,
    MD_ERS_SETUP   = 3'd2,
    MD_ERASING     = 3'd3,
    MD_ERS_VERIFY  = 3'd4,
    MD_PRG_SETUP   = 3'd5,
    MD_PROGRAMMING = 3'd6,
    MD_PRG_VERIFY  = 3'd7
  } fc_mode_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_READ,
    OP_IDENT,
    OP_ERASE,
    OP_ERS_VFY,
    OP_PROGRAM,
    OP_PRG_VFY,
    OP_RESET
  } fc_op_e;

  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_ERS_VFY = 8'hA0;
  localparam logic [7:0] CMD_PROGRAM = 8'h40;
  localparam logic [7:0] CMD_PRG_VFY = 8'hC0;

endpackage

// File: rtl/fc_bus_sync.sv
module fc_bus_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/fc_cmd_decode.sv
module fc_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] word,
  output fc_op_e            op
);

  logic [7:0] low_byte;
  assign low_byte = word[7:0];

  always_comb begin
    if (&word) begin
      op = OP_RESET;
    end else begin
      unique case (low_byte)
        CMD_READ:    op = OP_READ;
        CMD_IDENT:   op = OP_IDENT;
        CMD_ERASE:   op = OP_ERASE;
        CMD_ERS_VFY: op = OP_ERS_VFY;
        CMD_PROGRAM: op = OP_PROGRAM;
        CMD_PRG_VFY: op = OP_PRG_VFY;
        default:     op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/fc_mode_fsm.sv
module fc_mode_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  fc_op_e            op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output fc_mode_e          mode,
  output logic [ADDR_W-1:0] vfy_addr,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data
);

  fc_mode_e          mode_q, mode_d;
  logic              pend_q, pend_d;
  logic              ld_vfy, ld_prog;
  logic [ADDR_W-1:0] vfy_addr_q, prog_addr_q;
  logic [DATA_W-1:0] prog_data_q;

  always_comb begin
    mode_d  = mode_q;
    pend_d  = pend_q;
    ld_vfy  = 1'b0;
    ld_prog = 1'b0;
    if (wr_stb) begin
      if (mode_q == MD_PRG_SETUP) begin
        mode_d  = MD_PROGRAMMING;
        ld_prog = 1'b1;
        pend_d  = 1'b0;
      end else if (op == OP_RESET) begin
        if (pend_q) begin
          mode_d = MD_READ;
          pend_d = 1'b0;
        end else begin
          pend_d = 1'b1;
        end
      end else begin
        pend_d = 1'b0;
        if (mode_q == MD_ERS_SETUP) begin
          mode_d = (op == OP_ERASE) ? MD_ERASING : MD_READ;
        end else begin
          case (op)
            OP_READ:    mode_d = MD_READ;
            OP_IDENT:   mode_d = MD_IDENT;
            OP_ERASE:   mode_d = MD_ERS_SETUP;
            OP_ERS_VFY: begin
              mode_d = MD_ERS_VERIFY;
              ld_vfy = 1'b1;
            end
            OP_PROGRAM: mode_d = MD_PRG_SETUP;
            OP_PRG_VFY: mode_d = MD_PRG_VERIFY;
            default:    mode_d = mode_q;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_READ;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vfy_addr_q <= '0;
    end else if (ld_vfy) begin
      vfy_addr_q <= wr_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr_q <= '0;
      prog_data_q <= '0;
    end else if (ld_prog) begin
      prog_addr_q <= wr_addr;
      prog_data_q <= wr_data;
    end
  end

  assign mode      = mode_q;
  assign vfy_addr  = vfy_addr_q;
  assign prog_addr = prog_addr_q;
  assign prog_data = prog_data_q;

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(mode_q)) else $error("mode moved without a write"); // R2

  AST_ERASE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && mode_q == MD_ERS_SETUP && op == OP_ERASE) |=> (mode_q == MD_ERASING))
    else $error("erase confirm did not start erase"); // R3

  AST_ERASE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && mode_q == MD_ERASING && op == OP_ERS_VFY)
      |=> (mode_q == MD_ERS_VERIFY && vfy_addr_q == $past(wr_addr)))
    else $error("erase verify did not stop erase"); // R4

  AST_PRG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && mode_q == MD_PRG_SETUP)
      |=> (mode_q == MD_PROGRAMMING && prog_addr_q == $past(wr_addr)
           && prog_data_q == $past(wr_data)))
    else $error("program write not latched"); // R5

  AST_PRG_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && mode_q == MD_PROGRAMMING && op == OP_PRG_VFY) |=> (mode_q == MD_PRG_VERIFY))
    else $error("program verify did not stop program"); // R6

  AST_RESET_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && pend_q && op == OP_RESET && mode_q != MD_PRG_SETUP) |=> (mode_q == MD_READ))
    else $error("reset pair did not return to read"); // R7

  AST_UNKNOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && op == OP_NONE && mode_q != MD_PRG_SETUP && mode_q != MD_ERS_SETUP)
      |=> $stable(mode_q))
    else $error("unknown command changed mode"); // R9

endmodule

// File: rtl/fc_read_path.sv
module fc_read_path
  import flash_cmd_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0020,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h0050
) (
  input  fc_mode_e          mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] vfy_addr,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              margin_rd
);

  always_comb begin
    rd_addr   = bus_addr;
    margin_rd = 1'b0;
    case (mode)
      MD_ERS_VERIFY: begin
        rd_addr   = vfy_addr;
        margin_rd = 1'b1;
      end
      MD_PRG_VERIFY: begin
        rd_addr   = prog_addr;
        margin_rd = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (mode == MD_IDENT) rd_data = bus_addr[0] ? DEV_CODE : MFR_CODE;
    else                  rd_data = arr_rdata;
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [2:0]        mode,
  output logic              erase_busy,
  output logic              prog_busy,
  output logic              margin_rd,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int BUS_W = ADDR_W + DATA_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Strobe and bus synchronisers.
  logic [2:0]       strb_s;
  logic [BUS_W-1:0] bus_s;
  logic             ce_s_n, we_s_n, oe_s_n;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;

  fc_bus_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_strb_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({ce_n, we_n, oe_n}),
    .q     (strb_s)
  );

  fc_bus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({addr, din}),
    .q     (bus_s)
  );

  assign {ce_s_n, we_s_n, oe_s_n} = strb_s;
  assign {addr_s, din_s}          = bus_s;

  // Write-enable rising edge detection.
  logic we_prev_n;
  logic wr_stb;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) we_prev_n <= 1'b1;
    else            we_prev_n <= we_s_n;
  end

  always_comb begin
    wr_stb = we_s_n && !we_prev_n && !ce_s_n && oe_s_n;
  end

  fc_op_e            op;
  fc_mode_e          mode_i;
  logic [ADDR_W-1:0] vfy_addr;

  fc_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .word (din_s),
    .op   (op)
  );

  fc_mode_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_stb    (wr_stb),
    .op        (op),
    .wr_addr   (addr_s),
    .wr_data   (din_s),
    .mode      (mode_i),
    .vfy_addr  (vfy_addr),
    .prog_addr (prog_addr),
    .prog_data (prog_data)
  );

  fc_read_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .mode      (mode_i),
    .bus_addr  (addr_s),
    .vfy_addr  (vfy_addr),
    .prog_addr (prog_addr),
    .arr_rdata (arr_rdata),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .margin_rd (margin_rd)
  );

  assign mode       = mode_i;
  assign erase_busy = (mode_i == MD_ERASING);
  assign prog_busy  = (mode_i == MD_PROGRAMMING);

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_int_n |=> (mode == 3'd0 && !erase_busy && !prog_busy))
    else $error("not idle after reset"); // R1

endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, we_n, oe_n;
  logic [15:0] addr, din;
  logic [15:0] arr_rdata;
  logic [2:0]  mode;
  logic        erase_busy, prog_busy, margin_rd;
  logic [15:0] prog_addr, prog_data, rd_addr, rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [15:0] model(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C3C;
  endfunction

  assign arr_rdata = model(rd_addr);

  flash_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .arr_rdata(arr_rdata), .mode(mode),
    .erase_busy(erase_busy), .prog_busy(prog_busy), .margin_rd(margin_rd),
    .prog_addr(prog_addr), .prog_data(prog_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d,
                           input logic ce_v = 1'b0, input logic oe_v = 1'b1);
    @(negedge clk);
    addr = a; din = d; ce_n = ce_v; oe_n = oe_v; we_n = 1'b0;
    cyc(3);
    we_n = 1'b1;
    cyc(4);
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(2);
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d, output logic m);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    cyc(4);
    d = rd_data; m = margin_rd;
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(2);
  endtask

  task automatic t_reset_state;
    chk("R1 mode", {29'd0, mode}, 32'd0);
    chk("R1 erase_busy", {31'd0, erase_busy}, 32'd0);
    chk("R1 prog_busy", {31'd0, prog_busy}, 32'd0);
    chk("R1 margin", {31'd0, margin_rd}, 32'd0);
  endtask

  task automatic t_write_qual;
    bus_write(16'h0000, 16'h0090, 1'b0, 1'b0);
    chk("R2 oe low write ignored", {29'd0, mode}, 32'd0);
    bus_write(16'h0000, 16'h0090, 1'b1, 1'b1);
    chk("R2 ce high write ignored", {29'd0, mode}, 32'd0);
  endtask

  task automatic t_erase;
    logic [15:0] d; logic m;
    bus_write(16'h0000, 16'h0020);
    chk("R3 erase setup mode", {29'd0, mode}, 32'd2);
    chk("R3 no busy after first", {31'd0, erase_busy}, 32'd0);
    bus_write(16'h0000, 16'h0020);
    chk("R3 erasing mode", {29'd0, mode}, 32'd3);
    chk("R3 erase busy", {31'd0, erase_busy}, 32'd1);
    bus_write(16'h1234, 16'h00A0);
    chk("R4 verify mode", {29'd0, mode}, 32'd4);
    chk("R4 erase stopped", {31'd0, erase_busy}, 32'd0);
    bus_read(16'h0000, d, m);
    chk("R4 verify data", {16'd0, d}, {16'd0, model(16'h1234)});
    chk("R4 margin", {31'd0, m}, 32'd1);
    bus_write(16'h0042, 16'h00A0);
    bus_read(16'h0000, d, m);
    chk("R10 re-latched verify", {16'd0, d}, {16'd0, model(16'h0042)});
    bus_write(16'h0000, 16'h0077);
    chk("R9 unknown ignored", {29'd0, mode}, 32'd4);
    chk("R10 verify persists", {31'd0, margin_rd}, 32'd1);
    bus_write(16'h0000, 16'h0000);
    chk("R11 read command", {29'd0, mode}, 32'd0);
    bus_read(16'h0007, d, m);
    chk("R11 read data", {16'd0, d}, {16'd0, model(16'h0007)});
    chk("R11 no margin", {31'd0, m}, 32'd0);
  endtask

  task automatic t_erase_abort;
    bus_write(16'h0000, 16'h0020);
    bus_write(16'h0000, 16'h0055);
    chk("R3 abort to read", {29'd0, mode}, 32'd0);
    chk("R3 abort not busy", {31'd0, erase_busy}, 32'd0);
  endtask

  task automatic t_program;
    logic [15:0] d; logic m;
    bus_write(16'h0000, 16'h5540);
    chk("R9 upper byte ignored", {29'd0, mode}, 32'd5);
    bus_write(16'h0ABC, 16'hBEEF);
    chk("R5 programming", {29'd0, mode}, 32'd6);
    chk("R5 prog busy", {31'd0, prog_busy}, 32'd1);
    chk("R5 prog addr", {16'd0, prog_addr}, 32'h0ABC);
    chk("R5 prog data", {16'd0, prog_data}, 32'hBEEF);
    bus_write(16'h0000, 16'h00C0);
    chk("R6 verify mode", {29'd0, mode}, 32'd7);
    chk("R6 prog stopped", {31'd0, prog_busy}, 32'd0);
    bus_read(16'h3333, d, m);
    chk("R6 verify data", {16'd0, d}, {16'd0, model(16'h0ABC)});
    chk("R6 margin", {31'd0, m}, 32'd1);
  endtask

  task automatic t_reset_cmd;
    bus_write(16'h0000, 16'h0040);
    bus_write(16'h0100, 16'h1111);
    bus_write(16'h0000, 16'hFFFF);
    chk("R7 single reset keeps mode", {29'd0, mode}, 32'd6);
    bus_write(16'h0000, 16'hFFFF);
    chk("R7 reset pair to read", {29'd0, mode}, 32'd0);
    chk("R7 busy cleared", {31'd0, prog_busy}, 32'd0);
    bus_write(16'h0000, 16'hFFFF);
    bus_write(16'h0000, 16'h0090);
    chk("R7 cancel then decode", {29'd0, mode}, 32'd1);
    bus_write(16'h0000, 16'hFFFF);
    chk("R7 pending not done", {29'd0, mode}, 32'd1);
  endtask

  task automatic t_ident;
    logic [15:0] d; logic m;
    bus_write(16'h0000, 16'h0090);
    chk("R8 ident mode", {29'd0, mode}, 32'd1);
    bus_read(16'h0000, d, m);
    chk("R8 manufacturer code", {16'd0, d}, 32'h0020);
    bus_read(16'h0001, d, m);
    chk("R8 device code", {16'd0, d}, 32'h0050);
    bus_write(16'h0000, 16'h0000);
    chk("R11 back to read", {29'd0, mode}, 32'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; din = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    t_reset_state();
    t_write_qual();
    t_erase();
    t_erase_abort();
    t_program();
    t_reset_cmd();
    t_ident();
    finish_run();
  end

endmodule